// File: doc/BRIEF.md
# Packed Lane Add/Subtract Datapath

This block adds or subtracts two 32-bit words that are split into independent lanes, and registers the packed result one clock after an input strobe. A two-bit lane mode picks one of four lane layouts: two unsigned 16-bit lanes with optional clamping, four unsigned 8-bit averaging lanes, two signed 16-bit averaging lanes, or one signed 32-bit averaging lane. In all averaging layouts the lane sum or difference is formed wider than the lane, optionally has one added to it, and is then shifted right by one, so it cannot overflow.

The unsigned 16-bit layout is the only one that can overflow. An add whose true sum does not fit, or a subtract whose minuend is the smaller value, raises a one-cycle overflow pulse beside the result. This pulse is meant to be ORed by the surrounding core into a sticky status bit. With clamping enabled, the lane goes to the nearest representable value. With clamping off, the lane keeps the wrapped low bits.

Top module: `simd_addsub`

## Requirements
- R1: One clock edge after `in_valid` is sampled high, `out_valid` is high and `result` carries that operation. When `in_valid` is low at an edge, `out_valid` is low after it and `result` keeps its value.
- R2: While `rst` is high at a clock edge, `out_valid`, `ovf` and `result` are all cleared to zero.
- R3: In mode 2'b00 with `sub`=0, each 16-bit lane (lane 0 in bits 15:0) is a+b. When the true sum exceeds 0xFFFF, `ovf` is raised, and the lane becomes 0xFFFF if `sat_en`=1 or the low 16 bits of the sum otherwise.
- R4: In mode 2'b00 with `sub`=1, each 16-bit lane is a−b. When a < b (unsigned), `ovf` is raised, and the lane becomes 0x0000 if `sat_en`=1 or the wrapped 16-bit difference otherwise.
- R5: `ovf` is high only together with `out_valid`, for one cycle per overflowing operation. It is high if either 16-bit lane overflowed and low if neither did. `rnd_en` has no effect in mode 2'b00.
- R6: In mode 2'b01, each of four byte lanes (lane 0 in bits 7:0) is the low 8 bits of ((a ± b + rnd_en) >> 1), computed on zero-extended values without loss.
- R7: In mode 2'b10, each 16-bit lane is the low 16 bits of ((a ± b + rnd_en) >>> 1), computed on sign-extended values without loss.
- R8: In mode 2'b11, the whole word is ((a ± b + rnd_en) >>> 1) on signed 32-bit operands, computed at 33 bits or more so that the extreme operands give exact results.
- R9: Modes 2'b01, 2'b10 and 2'b11 never raise `ovf`, and `sat_en` has no effect on their results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| sub | input | 1 | 0 adds, 1 subtracts op_b from op_a |
| mode | input | 2 | Lane layout: 00 u16 clamp, 01 u8 average, 10 s16 average, 11 s32 average |
| sat_en | input | 1 | Clamp overflowing lanes in mode 00 |
| rnd_en | input | 1 | Add one before halving in modes 01, 10, 11 |
| out_valid | output | 1 | Result of the previous cycle's operation is valid |
| result | output | 32 | Packed lane result |
| ovf | output | 1 | One-cycle pulse: a 16-bit lane overflowed in mode 00 |

## Verification
The hard cases to reach from the ports sit at the edges of the operand range. One is the signed word average of two extreme values, where only the hidden 33rd bit keeps the answer right. Another is a mode 00 word where exactly one of the two halfword lanes overflows and the other does not. Uniform random operands almost never hit these. The stimulus therefore first applies directed extreme pairs, then draws each operand half from a small set of boundary values (zero, one, all ones, the sign bit alone, the largest positive value) mixed with fully random halves. Every cycle is compared against a behavioural integer model.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LM_U16_SAT = 2'b00,
        LM_U8_AVG  = 2'b01,
        LM_S16_AVG = 2'b10,
        LM_S32_AVG = 2'b11
    } lane_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              ovf;
    } lane_out_t;

endpackage

// File: rtl/simd_sat_lane.sv
module simd_sat_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sat,
    output logic [W-1:0] y,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        wide = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        // Top bit is carry-out on add and borrow on subtract.
        ovf  = wide[W];
        if (ovf && sat)
            y = sub ? '0 : '1;
        else
            y = wide[W-1:0];
    end
endmodule

// File: rtl/simd_halve_lane.sv
module simd_halve_lane #(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         rnd,
    output logic [W-1:0] y
);
    localparam int XW = W + 1;

    logic [XW-1:0] ax;
    logic [XW-1:0] bx;
    logic [XW-1:0] x;
    logic          lsb_unused;

    always_comb begin
        ax = SIGNED ? {a[W-1], a} : {1'b0, a};
        bx = SIGNED ? {b[W-1], b} : {1'b0, b};
        x  = sub ? (ax - bx) : (ax + bx);
        x  = x + XW'(rnd);
        // Bits W..1 are the halved value, whatever the shift kind.
        y  = x[W:1];
    end

    assign lsb_unused = x[0];
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          sub,
    input  logic [1:0]    mode,
    input  logic          sat_en,
    input  logic          rnd_en,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          ovf
);
    localparam int N_HALF = DW / HALF_W;
    localparam int N_BYTE = DW / BYTE_W;

    logic [DW-1:0]     r_u16;
    logic [DW-1:0]     r_u8;
    logic [DW-1:0]     r_s16;
    logic [DW-1:0]     r_s32;
    logic [N_HALF-1:0] lane_ovf;
    lane_out_t         nxt;
    lane_mode_e        lm;

    assign lm = lane_mode_e'(mode);

    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        simd_sat_lane #(.W(HALF_W)) u_sat (
            .a   (op_a[g*HALF_W +: HALF_W]),
            .b   (op_b[g*HALF_W +: HALF_W]),
            .sub (sub),
            .sat (sat_en),
            .y   (r_u16[g*HALF_W +: HALF_W]),
            .ovf (lane_ovf[g])
        );
        simd_halve_lane #(.W(HALF_W), .SIGNED(1'b1)) u_s16 (
            .a   (op_a[g*HALF_W +: HALF_W]),
            .b   (op_b[g*HALF_W +: HALF_W]),
            .sub (sub),
            .rnd (rnd_en),
            .y   (r_s16[g*HALF_W +: HALF_W])
        );
    end

    for (genvar g = 0; g < N_BYTE; g++) begin : g_byte
        simd_halve_lane #(.W(BYTE_W), .SIGNED(1'b0)) u_u8 (
            .a   (op_a[g*BYTE_W +: BYTE_W]),
            .b   (op_b[g*BYTE_W +: BYTE_W]),
            .sub (sub),
            .rnd (rnd_en),
            .y   (r_u8[g*BYTE_W +: BYTE_W])
        );
    end

    simd_halve_lane #(.W(DW), .SIGNED(1'b1)) u_s32 (
        .a   (op_a),
        .b   (op_b),
        .sub (sub),
        .rnd (rnd_en),
        .y   (r_s32)
    );

    always_comb begin
        nxt.ovf = 1'b0;
        unique case (lm)
            LM_U16_SAT: begin
                nxt.data = r_u16;
                nxt.ovf  = |lane_ovf;
            end
            LM_U8_AVG:  nxt.data = r_u8;
            LM_S16_AVG: nxt.data = r_s16;
            default:    nxt.data = r_s32;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ovf       <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            ovf       <= in_valid & nxt.ovf;
            if (in_valid)
                result <= nxt.data;
        end
    end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic          sub,
    input logic [1:0]    mode,
    input logic          sat_en,
    input logic          rnd_en,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic          ovf
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    a_r5_ovf_with_valid: assert property (@(posedge clk) disable iff (rst)
        ovf |-> out_valid);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != 2'b00) |=> !ovf);

    a_r3_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00 && !sub && sat_en &&
         op_a[15:0] == 16'hFFFF && op_b[15:0] != 16'h0000)
        |=> (result[15:0] == 16'hFFFF && ovf));

    a_r4_clamp_low: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00 && sub && sat_en &&
         op_a[15:0] < op_b[15:0])
        |=> (result[15:0] == 16'h0000 && ovf));

    a_r2_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf && result == '0));
endmodule

bind simd_addsub simd_addsub_chk #(.DW(DW)) u_chk (.*);

// File: tb/simd_addsub_test.sv
`timescale 1ns/1ps
module simd_addsub_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        sub;
    logic [1:0]  mode;
    logic        sat_en;
    logic        rnd_en;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    simd_addsub uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .sub(sub), .mode(mode),
        .sat_en(sat_en), .rnd_en(rnd_en),
        .out_valid(out_valid), .result(result), .ovf(ovf)
    );

    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic s, input logic [1:0] m,
                                          input logic sat, input logic rnd);
        logic [31:0] r = '0;
        logic        o = 1'b0;
        case (m)
            2'b00: for (int i = 0; i < 2; i++) begin
                int x = int'(a[i*16 +: 16]);
                int y = int'(b[i*16 +: 16]);
                int v = s ? x - y : x + y;
                if (v > 65535 || v < 0) begin
                    o = 1'b1;
                    if (sat) v = (v < 0) ? 0 : 65535;
                end
                r[i*16 +: 16] = 16'(v);
            end
            2'b01: for (int i = 0; i < 4; i++) begin
                int x = int'(a[i*8 +: 8]);
                int y = int'(b[i*8 +: 8]);
                int v = (s ? x - y : x + y) + int'(rnd);
                r[i*8 +: 8] = 8'(v >>> 1);
            end
            2'b10: for (int i = 0; i < 2; i++) begin
                int x = int'($signed(a[i*16 +: 16]));
                int y = int'($signed(b[i*16 +: 16]));
                int v = (s ? x - y : x + y) + int'(rnd);
                r[i*16 +: 16] = 16'(v >>> 1);
            end
            default: begin
                longint x = longint'($signed(a));
                longint y = longint'($signed(b));
                longint v = (s ? x - y : x + y) + longint'(rnd);
                r = 32'(v >>> 1);
            end
        endcase
        return {o, r};
    endfunction

    function automatic string tag(input logic [1:0] m, input logic s);
        case (m)
            2'b00:   return s ? "R4" : "R3";
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual ovf=%b data=%08h, expected ovf=%b data=%08h",
                     req, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic [1:0] m, input logic sat, input logic rnd);
        logic [32:0] exp = model(a, b, s, m, sat, rnd);
        op_a = a; op_b = b; sub = s; mode = m; sat_en = sat; rnd_en = rnd;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1", {32'd0, out_valid}, {32'd0, 1'b1});
        check(tag(m, s), {ovf, result}, exp);
        if (m != 2'b00) check("R9", {32'd0, ovf}, 33'd0);
        in_valid = 1'b0;
    endtask

    function automatic logic [15:0] edge16();
        case ($urandom % 6)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h8000;
            4: return 16'h7FFF;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual run still going, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
        sub = 1'b0; mode = 2'b00; sat_en = 1'b0; rnd_en = 1'b0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2", {out_valid, result}, 33'd0);
        check("R2", {32'd0, ovf}, 33'd0);
        rst = 1'b0;
        @(negedge clk);

        // R3 lane 0 only overflows, clamp on and off
        apply(32'h0001_FFFF, 32'h0001_0002, 1'b0, 2'b00, 1'b1, 1'b0);
        apply(32'h0001_FFFF, 32'h0001_0002, 1'b0, 2'b00, 1'b0, 1'b0);
        // R3 lane 1 only, rnd_en ignored (R5)
        apply(32'hFFFF_0001, 32'h0001_0001, 1'b0, 2'b00, 1'b1, 1'b1);
        // R5 no lane overflow: exact fit
        apply(32'h8000_7FFF, 32'h7FFF_8000, 1'b0, 2'b00, 1'b1, 1'b0);
        // R4 borrow cases
        apply(32'h0005_0000, 32'h0003_0001, 1'b1, 2'b00, 1'b1, 1'b0);
        apply(32'h0005_0000, 32'h0003_0001, 1'b1, 2'b00, 1'b0, 1'b0);
        apply(32'h1234_1234, 32'h1234_1234, 1'b1, 2'b00, 1'b1, 1'b0);
        // R6 byte averages
        apply(32'hFF00_FF01, 32'hFF01_0001, 1'b0, 2'b01, 1'b0, 1'b1);
        apply(32'h0000_FF01, 32'h01FF_0002, 1'b1, 2'b01, 1'b1, 1'b1);
        // R7 signed halfwords
        apply(32'h8000_7FFF, 32'h8000_7FFF, 1'b0, 2'b10, 1'b0, 1'b1);
        apply(32'h8000_7FFF, 32'h7FFF_8000, 1'b1, 2'b10, 1'b1, 1'b0);
        // R8 word extremes
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 2'b11, 1'b0, 1'b1);
        apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'b11, 1'b0, 1'b0);
        apply(32'h8000_0000, 32'h8000_0000, 1'b0, 2'b11, 1'b1, 1'b1);
        apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 2'b11, 1'b0, 1'b1);

        // R1 idle hold and R5 pulse drop
        held = result;
        @(negedge clk);
        check("R1", {out_valid, result}, {1'b0, held});
        check("R5", {32'd0, ovf}, 33'd0);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] a = {edge16(), edge16()};
            logic [31:0] b = {edge16(), edge16()};
            apply(a, b, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
            if (n % 7 == 0) begin
                held = result;
                @(negedge clk);
                check("R1", {out_valid, result}, {1'b0, held});
            end
        end

        // R2 reset mid-stream clears everything
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R2", {out_valid, result}, 33'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule